// File: doc/BRIEF.md
# HDLC Transmit Bit Stuffer

This block turns a stream of frame bytes for one serial channel into an HDLC-style bit stream. A frame opens with a 0x7E flag. Its bytes follow, least significant bit first, and a 16-bit frame check sequence comes after them. A closing 0x7E flag ends the frame. Inside the frame body, which covers the data and check bits, a zero is inserted after every five consecutive ones, so that the flag pattern cannot appear between the flags. While no frame is being sent, the line carries an idle fill. The fill is either a steady one level or back-to-back 0x7E flags, chosen by a static configuration pin. A second static pin complements the line level for channels wired with inverted polarity.

Bytes enter on a valid/ready stream. A transfer happens on any clock edge where `s_valid` and `s_ready` are both high. Once the source raises `s_valid`, it keeps the byte and the `last` marker steady until the transfer. `s_ready` rises only when the block needs the next byte of a frame, and it stays low during the opening flag, a stuffed zero, the check sequence and the closing flag. The serial side advances one bit per clock edge on which `bit_en` is high. The source must supply each byte by the bit slot that needs it. If the byte is missing at that slot, the frame is aborted.

Top module: `hdlc_tx_stuffer`

## Requirements
- R1: During and right after reset, `s_ready` is low and `tx_line` is at the idle level: 1, or 0 when `cfg_invert` is set.
- R2: Outside a frame, the line sends the idle fill. With `cfg_idle_flags`=0 the fill is all ones. With `cfg_idle_flags`=1 it is repeated 0x7E bytes, least significant bit first, and the first idle bit after reset is bit 0 of a flag.
- R3: A frame starts only at the end of an 8-bit idle unit where `s_valid` is high. The first 8 bits of the frame are the flag 0x7E, sent LSB first and never stuffed.
- R4: `tx_line` changes only on clock edges where `bit_en` is high, one bit per such edge. Data bytes go out LSB first in the order they were transferred.
- R5: In the data and check fields, a 0 is inserted after each run of five consecutive 1 bits. The run count restarts at every frame start. A stuffed zero is also inserted before the closing flag if the last check bit ends a run of five.
- R6: After the byte marked `s_last`, the block sends the ones complement of a CRC-16 (polynomial x^16+x^12+x^5+1, bit-reflected form 0x8408, preset 0xFFFF). The CRC is computed over the unstuffed data bits in line order and sent LSB first.
- R7: The check field is followed by the flag 0x7E, and then the idle fill resumes at bit 0 of a new idle unit.
- R8: With `cfg_invert`=1, `tx_line` is the complement of the bit the non-inverted channel would send.
- R9: `s_ready` is high only while the block is inside a frame body, holds no pending byte and owes no stuffed zero, or while it is discarding an aborted frame. It is low in every other phase.
- R10: If a data bit slot finds no byte held and `s_valid` low, the block sends eight 1 bits (abort) and returns to idle. `s_ready` then stays high until a byte marked `s_last` has been taken. Those bytes are discarded and start no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Serial bit slot enable, one line bit per high cycle |
| cfg_idle_flags | input | 1 | Idle fill select: 0 all ones, 1 repeated 0x7E |
| cfg_invert | input | 1 | Complement the serial line level |
| s_valid | input | 1 | Byte stream valid |
| s_data | input | 8 | Byte stream data, bit 0 sent first |
| s_last | input | 1 | Marks the final byte of a frame |
| s_ready | output | 1 | Byte stream ready |
| tx_line | output | 1 | Serial line output |

## Verification
An off-by-one in the bit counter moves the flag boundaries. This shows on the line within one 8-slot unit, as a shifted opening or closing flag or as a frame that starts a unit late. A run counter that drifts produces a missing or extra zero within the next six body bits, and every later bit of that frame lands one slot off. A corrupted CRC register is only visible in the 16 check bits at the frame's end. A wrong phase flag shows up as `s_ready` high during a flag or check field, or, on underrun, as the abort pattern missing in the slot that lacked a byte.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam logic [BYTE_W-1:0] FLAG_BYTE = 8'h7E;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_OPEN  = 3'd1,
    ST_DATA  = 3'd2,
    ST_CRC   = 3'd3,
    ST_CLOSE = 3'd4,
    ST_ABORT = 3'd5
  } tx_state_e;
endpackage

// File: rtl/hdlc_tx_crc.sv
module hdlc_tx_crc #(
  parameter int unsigned CRC_W = 16,
  parameter logic [CRC_W-1:0] CRC_POLY = 16'h8408,
  parameter logic [CRC_W-1:0] CRC_INIT = 16'hFFFF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic feed,
  input  logic din,
  input  logic shift,
  output logic crc_bit
);
  logic [CRC_W-1:0] crc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= CRC_INIT;
    end else if (clear) begin
      crc_q <= CRC_INIT;
    end else if (feed) begin
      crc_q <= (crc_q >> 1) ^ ((crc_q[0] ^ din) ? CRC_POLY : '0);
    end else if (shift) begin
      crc_q <= crc_q >> 1;
    end
  end

  // complemented value goes out, lowest bit first
  assign crc_bit = ~crc_q[0];
endmodule

// File: rtl/hdlc_tx_ones.sv
module hdlc_tx_ones #(
  parameter int unsigned RUN = 5,
  localparam int unsigned RUN_W = $clog2(RUN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             bump,
  input  logic             bit_val,
  output logic             stuff_due,
  output logic [RUN_W-1:0] run_cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
    end else if (clear) begin
      run_cnt <= '0;
    end else if (bump) begin
      run_cnt <= bit_val ? run_cnt + 1'b1 : '0;
    end
  end

  assign stuff_due = (run_cnt == RUN_W'(RUN));
endmodule

// File: rtl/hdlc_tx_fsm.sv
module hdlc_tx_fsm
  import hdlc_tx_pkg::*;
#(
  parameter int unsigned CRC_W = 16,
  localparam int unsigned CNT_W = $clog2(CRC_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              cfg_idle_flags,
  input  logic              s_valid,
  input  logic [BYTE_W-1:0] s_data,
  input  logic              s_last,
  output logic              s_ready,
  input  logic              stuff_due,
  input  logic              crc_bit,
  output logic              out_bit,
  output logic              crc_clr,
  output logic              crc_feed,
  output logic              crc_shift,
  output logic              ones_clr,
  output logic              ones_bump,
  output tx_state_e         state_o,
  output logic              drop_o
);
  localparam logic [CNT_W-1:0] CCNT_LAST = CNT_W'(CRC_W - 1);

  tx_state_e         state;
  logic [2:0]        bcnt;
  logic [BYTE_W-1:0] shreg;
  logic              empty;
  logic              last_q;
  logic              drop;
  logic [CNT_W-1:0]  ccnt;
  logic              hs;
  logic              start;

  assign s_ready = drop || (state == ST_DATA && empty && !stuff_due);
  assign hs      = s_valid && s_ready;
  assign start   = bit_en && state == ST_IDLE && bcnt == 3'd7 && s_valid && !drop;
  assign crc_clr  = start;
  assign ones_clr = start;
  assign state_o  = state;
  assign drop_o   = drop;

  always_comb begin
    out_bit   = 1'b1;
    crc_feed  = 1'b0;
    crc_shift = 1'b0;
    ones_bump = 1'b0;
    unique case (state)
      ST_IDLE:  out_bit = cfg_idle_flags ? FLAG_BYTE[bcnt] : 1'b1;
      ST_OPEN:  out_bit = FLAG_BYTE[bcnt];
      ST_DATA: begin
        if (stuff_due) begin
          out_bit   = 1'b0;
          ones_bump = bit_en;
        end else if (!empty) begin
          out_bit   = shreg[0];
          crc_feed  = bit_en;
          ones_bump = bit_en;
        end else if (s_valid) begin
          out_bit   = s_data[0];
          crc_feed  = bit_en;
          ones_bump = bit_en;
        end
      end
      ST_CRC: begin
        if (stuff_due) begin
          out_bit   = 1'b0;
          ones_bump = bit_en;
        end else begin
          out_bit   = crc_bit;
          crc_shift = bit_en;
          ones_bump = bit_en;
        end
      end
      ST_CLOSE: begin
        if (stuff_due && bcnt == 3'd0) begin
          out_bit   = 1'b0;
          ones_bump = bit_en;
        end else begin
          out_bit = FLAG_BYTE[bcnt];
        end
      end
      default: out_bit = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      bcnt   <= 3'd0;
      shreg  <= '0;
      empty  <= 1'b1;
      last_q <= 1'b0;
      drop   <= 1'b0;
      ccnt   <= '0;
    end else begin
      if (hs && drop && s_last) drop <= 1'b0;
      if (hs && !drop && !bit_en) begin
        shreg  <= s_data;
        bcnt   <= 3'd0;
        empty  <= 1'b0;
        last_q <= s_last;
      end
      if (bit_en) begin
        unique case (state)
          ST_IDLE: begin
            bcnt <= bcnt + 3'd1;
            if (start) state <= ST_OPEN;
          end
          ST_OPEN: begin
            bcnt <= bcnt + 3'd1;
            if (bcnt == 3'd7) begin
              state <= ST_DATA;
              empty <= 1'b1;
            end
          end
          ST_DATA: begin
            if (!stuff_due) begin
              if (!empty) begin
                shreg <= shreg >> 1;
                bcnt  <= bcnt + 3'd1;
                if (bcnt == 3'd7) begin
                  empty <= 1'b1;
                  if (last_q) begin
                    state <= ST_CRC;
                    ccnt  <= '0;
                  end
                end
              end else if (s_valid) begin
                shreg  <= s_data >> 1;
                bcnt   <= 3'd1;
                empty  <= 1'b0;
                last_q <= s_last;
              end else begin
                state <= ST_ABORT;
                bcnt  <= 3'd1;
                drop  <= 1'b1;
              end
            end
          end
          ST_CRC: begin
            if (!stuff_due) begin
              ccnt <= ccnt + 1'b1;
              if (ccnt == CCNT_LAST) begin
                state <= ST_CLOSE;
                bcnt  <= 3'd0;
              end
            end
          end
          ST_CLOSE: begin
            if (!(stuff_due && bcnt == 3'd0)) begin
              bcnt <= bcnt + 3'd1;
              if (bcnt == 3'd7) state <= ST_IDLE;
            end
          end
          ST_ABORT: begin
            bcnt <= bcnt + 3'd1;
            if (bcnt == 3'd7) state <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/hdlc_tx_stuffer.sv
module hdlc_tx_stuffer
  import hdlc_tx_pkg::*;
#(
  parameter int unsigned STUFF_RUN = 5,
  parameter int unsigned CRC_W = 16,
  parameter logic [CRC_W-1:0] CRC_POLY = 16'h8408,
  parameter logic [CRC_W-1:0] CRC_INIT = 16'hFFFF,
  localparam int unsigned RUN_W = $clog2(STUFF_RUN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              cfg_idle_flags,
  input  logic              cfg_invert,
  input  logic              s_valid,
  input  logic [BYTE_W-1:0] s_data,
  input  logic              s_last,
  output logic              s_ready,
  output logic              tx_line
);
  logic             out_bit, crc_bit, stuff_due;
  logic             crc_clr, crc_feed, crc_shift, ones_clr, ones_bump;
  logic             line_q, drop_w;
  logic [RUN_W-1:0] run_cnt;
  tx_state_e        state_w;

  hdlc_tx_fsm #(.CRC_W(CRC_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .cfg_idle_flags(cfg_idle_flags),
    .s_valid(s_valid), .s_data(s_data), .s_last(s_last), .s_ready(s_ready),
    .stuff_due(stuff_due), .crc_bit(crc_bit), .out_bit(out_bit),
    .crc_clr(crc_clr), .crc_feed(crc_feed), .crc_shift(crc_shift),
    .ones_clr(ones_clr), .ones_bump(ones_bump), .state_o(state_w), .drop_o(drop_w)
  );

  hdlc_tx_crc #(.CRC_W(CRC_W), .CRC_POLY(CRC_POLY), .CRC_INIT(CRC_INIT)) u_crc (
    .clk(clk), .rst_n(rst_n), .clear(crc_clr), .feed(crc_feed), .din(out_bit),
    .shift(crc_shift), .crc_bit(crc_bit)
  );

  hdlc_tx_ones #(.RUN(STUFF_RUN)) u_ones (
    .clk(clk), .rst_n(rst_n), .clear(ones_clr), .bump(ones_bump), .bit_val(out_bit),
    .stuff_due(stuff_due), .run_cnt(run_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= 1'b1;
    else if (bit_en) line_q <= out_bit;
  end

  assign tx_line = line_q ^ cfg_invert;
endmodule

// File: rtl/hdlc_tx_stuffer_chk.sv
module hdlc_tx_stuffer_chk
  import hdlc_tx_pkg::*;
#(
  parameter int unsigned RUN = 5,
  parameter int unsigned RUN_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bit_en,
  input logic             cfg_idle_flags,
  input logic             s_ready,
  input tx_state_e        state,
  input logic [RUN_W-1:0] run_cnt,
  input logic             line_q,
  input logic             drop
);
  // R9
  ready_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> (state == ST_DATA || drop));

  // R5
  run_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_cnt <= RUN_W'(RUN));

  // R4
  line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(line_q));

  // R2
  idle_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !cfg_idle_flags && bit_en) |=> line_q);

  // R10
  abort_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ABORT && bit_en) |=> line_q);

  // R3
  open_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_OPEN && $past(state) != ST_OPEN) |-> $past(state) == ST_IDLE);
endmodule

bind hdlc_tx_stuffer hdlc_tx_stuffer_chk #(.RUN(STUFF_RUN), .RUN_W(RUN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .cfg_idle_flags(cfg_idle_flags),
  .s_ready(s_ready), .state(state_w), .run_cnt(run_cnt), .line_q(line_q), .drop(drop_w)
);

// File: tb/hdlc_tx_stuffer_bench.sv
`timescale 1ns/1ps
module hdlc_tx_stuffer_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_en = 1'b0;
  logic cfg_idle_flags = 1'b0;
  logic cfg_invert = 1'b0;
  logic s_valid = 1'b0;
  logic [7:0] s_data = 8'h00;
  logic s_last = 1'b0;
  logic s_ready;
  logic tx_line;

  always #2.5 clk = ~clk;

  hdlc_tx_stuffer u_hdlc_tx_stuffer (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .cfg_idle_flags(cfg_idle_flags),
    .cfg_invert(cfg_invert), .s_valid(s_valid), .s_data(s_data), .s_last(s_last),
    .s_ready(s_ready), .tx_line(tx_line)
  );

  // {idle_flags, invert, byte count, bytes (byte 0 in bits 7:0)}
  localparam logic [36:0] VEC [8] = '{
    {1'b0, 1'b0, 3'd1, 32'h0000_00A5},
    {1'b1, 1'b0, 3'd2, 32'h0000_3C5A},
    {1'b0, 1'b1, 3'd3, 32'h00FF_FFFF},
    {1'b1, 1'b1, 3'd4, 32'hF8F8_1F7E},
    {1'b0, 1'b0, 3'd4, 32'h1234_5678},
    {1'b1, 1'b0, 3'd1, 32'h0000_00FF},
    {1'b0, 1'b0, 3'd2, 32'h0000_00F8},
    {1'b1, 1'b1, 3'd2, 32'h0000_3E7C}
  };

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  logic exp_b [128];
  logic got_b [128];
  logic rdy_post [128];
  int   exp_len;
  int   idx;
  int   nbytes;
  int   hold_at;
  logic [31:0] dat;
  int   hold_bad;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv,
                     input string what);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // one clock; inputs change only after the rising edge
  task automatic tick(input logic en, output logic rdy);
    logic hs;
    @(negedge clk);
    bit_en = en;
    rdy = s_ready;
    hs = s_valid && s_ready;
    @(posedge clk);
    #1;
    if (hs) begin
      idx++;
      if (idx >= nbytes) begin
        s_valid = 1'b0;
      end else begin
        s_data = dat[idx*8 +: 8];
        s_last = (idx == nbytes - 1);
        if (idx == hold_at) s_valid = 1'b0;
      end
    end
  endtask

  task automatic slot(input int k, output logic rdy_any);
    logic r, r2, v;
    tick(1'b1, r);
    v = tx_line;
    got_b[k] = v;
    tick(1'b0, r);
    tick(1'b0, r2);
    rdy_post[k] = r | r2;
    rdy_any = r | r2;
    if (tx_line !== v) hold_bad++;
  endtask

  task automatic do_reset();
    logic r;
    s_valid = 1'b0;
    rst_n = 1'b0;
    tick(1'b0, r);
    tick(1'b0, r);
    rst_n = 1'b1;
    tick(1'b0, r);
  endtask

  task automatic push(input logic b, inout int n, inout int ones, inout logic [15:0] c,
                      input bit body, input bit fcs);
    exp_b[n] = b;
    n++;
    if (body) begin
      if (!fcs) begin
        c = (c >> 1) ^ ((c[0] ^ b) ? 16'h8408 : 16'h0000);
      end
      ones = b ? ones + 1 : 0;
      if (ones == 5) begin
        exp_b[n] = 1'b0;
        n++;
        ones = 0;
      end
    end
  endtask

  // expected line bits (before inversion), from reset to one idle unit after the frame
  task automatic build(input bit idlef, input int n, input logic [31:0] d);
    int p = 0;
    int ones = 0;
    logic [15:0] c = 16'hFFFF;
    logic [15:0] fcs;
    for (int i = 0; i < 8; i++) push(idlef ? 1'((8'h7E >> i) & 1) : 1'b1, p, ones, c, 0, 0);
    for (int i = 0; i < 8; i++) push(1'((8'h7E >> i) & 1), p, ones, c, 0, 0);
    for (int j = 0; j < n; j++)
      for (int i = 0; i < 8; i++) push(d[j*8 + i], p, ones, c, 1, 0);
    fcs = ~c;
    for (int i = 0; i < 16; i++) push(fcs[i], p, ones, c, 1, 1);
    for (int i = 0; i < 8; i++) push(1'((8'h7E >> i) & 1), p, ones, c, 0, 0);
    for (int i = 0; i < 8; i++) push(idlef ? 1'((8'h7E >> i) & 1) : 1'b1, p, ones, c, 0, 0);
    exp_len = p;
  endtask

  task automatic run_frame(input bit idlef, input bit inv, input int n, input logic [31:0] d,
                           input string tag);
    int bad = 0;
    int early = 0;
    int late = 0;
    int first_bad = -1;
    logic r;
    bit taken;
    cfg_idle_flags = idlef;
    cfg_invert = inv;
    hold_at = -1;
    dat = d;
    nbytes = n;
    idx = 0;
    hold_bad = 0;
    do_reset();
    // R1 reset level and ready
    chk("R1", {30'd0, s_ready, tx_line}, {30'd0, 1'b0, ~inv}, {tag, " reset ready/line"});
    build(idlef, n, d);
    s_data = d[7:0];
    s_last = (n == 1);
    s_valid = 1'b1;
    for (int k = 0; k < exp_len; k++) begin
      taken = (idx == n);
      slot(k, r);
      if (got_b[k] !== (exp_b[k] ^ inv)) begin
        bad++;
        if (first_bad < 0) first_bad = k;
      end
      if (k <= 14 && r) early++;
      if (taken && r) late++;
    end
    // R2 R3 R5 R6 R7 R8: full line sequence
    chk("R6", bad, 0, $sformatf("%s line bit mismatches (first slot %0d)", tag, first_bad));
    // R4 all bytes taken and line held between slots
    chk("R4", {idx, hold_bad}, {n, 0}, {tag, " bytes taken / hold errors"});
    // R9 ready low in idle/opening flag and after the last byte
    chk("R9", {early, late}, 0, {tag, " ready in flag/check phases"});
  endtask

  initial begin
    logic r;
    bit ok;
    for (int v = 0; v < 8; v++) begin
      run_frame(VEC[v][36], VEC[v][35], int'(VEC[v][34:32]), VEC[v][31:0],
                $sformatf("vec%0d", v));
    end

    // R5 R9: stuffed zero right after a byte boundary blocks ready, then ready returns
    run_frame(1'b0, 1'b0, 2, 32'h0000_00F8, "stuff_edge");
    chk("R5", got_b[24], 1'b0, "stuffed zero after 0xF8");
    chk("R9", {rdy_post[23], rdy_post[24]}, 2'b01, "ready around stuffed zero");

    // R2: flag idle starts at bit 0 of a flag right after reset
    cfg_idle_flags = 1'b1;
    cfg_invert = 1'b0;
    hold_at = -1;
    nbytes = 0;
    idx = 0;
    do_reset();
    for (int k = 0; k < 16; k++) slot(k, r);
    ok = 1'b1;
    for (int k = 0; k < 16; k++) if (got_b[k] !== 1'((8'h7E >> (k % 8)) & 1)) ok = 1'b0;
    chk("R2", ok, 1'b1, "flag idle pattern with no traffic");

    // R10: underrun aborts, later bytes up to last are discarded
    cfg_idle_flags = 1'b0;
    cfg_invert = 1'b0;
    dat = 32'h0000_5500;
    nbytes = 2;
    idx = 0;
    hold_at = 1;
    do_reset();
    s_data = 8'h00;
    s_last = 1'b0;
    s_valid = 1'b1;
    for (int k = 0; k < 32; k++) slot(k, r);
    ok = 1'b1;
    for (int k = 16; k < 24; k++) if (got_b[k] !== 1'b0) ok = 1'b0;
    chk("R4", ok, 1'b1, "byte 0x00 before underrun");
    ok = 1'b1;
    for (int k = 24; k < 32; k++) if (got_b[k] !== 1'b1) ok = 1'b0;
    chk("R10", ok, 1'b1, "eight abort ones");
    s_valid = 1'b1;
    for (int k = 32; k < 56; k++) slot(k, r);
    chk("R10", idx, 2, "last byte drained");
    ok = 1'b1;
    for (int k = 32; k < 56; k++) if (got_b[k] !== 1'b1) ok = 1'b0;
    chk("R10", ok, 1'b1, "no frame from drained bytes");

    // R1: reset in the middle of a frame
    cfg_idle_flags = 1'b1;
    cfg_invert = 1'b1;
    dat = 32'h0000_00FF;
    nbytes = 1;
    idx = 0;
    hold_at = -1;
    do_reset();
    s_data = 8'hFF;
    s_last = 1'b1;
    s_valid = 1'b1;
    for (int k = 0; k < 20; k++) slot(k, r);
    s_valid = 1'b0;
    rst_n = 1'b0;
    tick(1'b0, r);
    chk("R1", {s_ready, tx_line}, 2'b00, "mid-frame reset, inverted idle level");
    rst_n = 1'b1;
    tick(1'b0, r);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #900000;
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL R4 watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule